// File: doc/BRIEF.md
# Serial Audio Link Power-Down and Wake Controller

This block sits on the codec side of a serial audio link. It watches the register writes that the frame decoder extracts from incoming frames. When a write to the power-down register has the link-halt bit set, it stops the bit clock output at once and holds the serial data returned to the controller low. It then waits for one of two wake protocols. A warm wake is a long high pulse on the frame sync line while the link is stopped. A cold wake is the asynchronous active-low reset input. After either one, it restarts the link.

Only a cold wake or a write to the reset register returns the register file to its defaults. For that the block drives `reg_defaults`. A warm wake only clears the link-halt bit, through the one-cycle strobe `halt_bit_clr`, and every other register keeps its value. The bit clock is stopped while halted, so the warm-wake pulse is timed against `clk`, a free-running internal oscillator. `link_halted` tells the frame builder to keep its shift register idle.

The controller is a state machine with six states. ST_COLD is held while reset is low and lasts one cycle after release. It then goes to ST_RUN, the normal link. ST_RUN goes to ST_HALT on a halt write. ST_HALT goes to ST_MEAS when sync is seen high. ST_MEAS returns to ST_HALT if sync falls early, or goes on to ST_ARMED once the pulse is long enough. ST_ARMED waits for sync to fall and then goes to ST_WAKE. ST_WAKE lasts one cycle, clears the halt bit and returns to ST_RUN. A low reset input forces ST_COLD from any state.

Top module: `lpw_link_power`

## Requirements
- R1: While `rst_n` is low: `bit_clk_out` and `sdata_in_out` are 0, and `link_halted` and `reg_defaults` are 1. One cycle after release, the link runs: `link_halted`=0, `bit_clk_out` follows `bit_clk_src`, `sdata_in_out` follows `sdata_src`, and `reg_defaults`=0.
- R2: A write with `wr_addr`=7'h26 and `wr_data` bit 12 set, made while running, halts the link at that clock edge. From then on `link_halted`=1 and both `bit_clk_out` and `sdata_in_out` are 0.
- R3: A write to 7'h26 with bit 12 clear, or a write to any address other than 7'h26 and 7'h00, leaves the link running and changes no output.
- R4: While halted, sync held low and any register write, including a halt or reset-register write, leave the block halted with `reg_defaults`=0.
- R5: A sync high pulse sampled on fewer than WARM_CYCLES (default 50, 1 µs at 50 MHz) clock edges leaves the link halted, with `halt_bit_clr`=0.
- R6: A sync pulse sampled high on at least WARM_CYCLES edges keeps the link halted while sync stays high. After sync falls, `halt_bit_clr`=1 for exactly one cycle with the link still halted, and the link runs on the next cycle.
- R7: A write to 7'h00 while running sets `reg_defaults`=1 for exactly one cycle, starting the cycle after the write edge, and the link keeps running. A warm wake never asserts `reg_defaults`.
- R8: Asserting `rst_n` low while halted forces the cold state (R1 outputs), and the link runs after release without any sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Decoded register write strobe |
| wr_addr | input | 7 | Decoded register write address |
| wr_data | input | 16 | Decoded register write data |
| sync_in | input | 1 | Frame sync from the controller |
| bit_clk_src | input | 1 | Generated bit clock before gating |
| sdata_src | input | 1 | Serial data from the frame builder |
| bit_clk_out | output | 1 | Gated bit clock to the link |
| sdata_in_out | output | 1 | Gated serial data to the controller |
| link_halted | output | 1 | Link is not in normal running state |
| halt_bit_clr | output | 1 | One-cycle strobe clearing the link-halt register bit |
| reg_defaults | output | 1 | Return the register file to default values |

## Verification
The power-down write and the reset-register write come from the same decoder, and a cold reset can overlap any halted state. Two cases in which these meet are exercised. In the first, a reset-register write lands while the link is halted; it must produce no `reg_defaults` pulse. In the second, `rst_n` is pulled low in the middle of the halt, right after a short sync pulse; the cold path must win, with no warm-wake strobe. Random writes mixing both addresses with random data are checked against bench-computed halt and pulse expectations. Random sync pulse lengths, including lengths of exactly WARM_CYCLES-1 and WARM_CYCLES, are judged by a bench function that compares the length with the threshold.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    typedef enum logic [2:0] {
        ST_COLD,
        ST_RUN,
        ST_HALT,
        ST_MEAS,
        ST_ARMED,
        ST_WAKE
    } lpw_state_t;
endpackage

// File: rtl/lpw_wr_decode.sv
module lpw_wr_decode #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 16,
    parameter int PD_ADDR  = 'h26,
    parameter int RST_ADDR = 'h00,
    parameter int HALT_BIT = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              halt_hit,
    output logic              rstreg_hit
);
    localparam logic [ADDR_W-1:0] PD_A  = ADDR_W'(PD_ADDR);
    localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RST_ADDR);

    always_comb begin
        halt_hit   = wr_en && (wr_addr == PD_A) && wr_data[HALT_BIT];
        rstreg_hit = wr_en && (wr_addr == RST_A);
    end
endmodule

// File: rtl/lpw_wake_timer.sv
module lpw_wake_timer #(
    parameter int WARM_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic reached
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(WARM_CYCLES - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (cnt < LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt >= LIM);

    // R5: the pulse counter never runs past its threshold
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm
    import lpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_hit,
    input  logic       rstreg_hit,
    input  logic       sync_in,
    input  logic       timer_done,
    output lpw_state_t state,
    output logic       timer_en,
    output logic       halt_bit_clr,
    output logic       reg_defaults
);
    lpw_state_t nxt;
    logic       rstw_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLD:  nxt = ST_RUN;
            ST_RUN:   if (halt_hit) nxt = ST_HALT;
            ST_HALT:  if (sync_in) nxt = ST_MEAS;
            ST_MEAS: begin
                if (!sync_in)        nxt = ST_HALT;
                else if (timer_done) nxt = ST_ARMED;
            end
            ST_ARMED: if (!sync_in) nxt = ST_WAKE;
            ST_WAKE:  nxt = ST_RUN;
            default:  nxt = ST_COLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COLD;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rstw_q <= 1'b0;
        end else begin
            rstw_q <= rstreg_hit && (state == ST_RUN);
        end
    end

    always_comb begin
        timer_en     = (state == ST_MEAS);
        halt_bit_clr = (state == ST_WAKE);
        reg_defaults = (state == ST_COLD) || rstw_q;
    end

    p_halt_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && halt_hit) |=> (state == ST_HALT));

    p_halt_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !sync_in) |=> (state == ST_HALT));

    p_short_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEAS && !sync_in) |=> (state == ST_HALT));

    p_armed_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && sync_in) |=> (state == ST_ARMED));

    p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_bit_clr |=> !halt_bit_clr && (state == ST_RUN));

    p_defaults_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_defaults && state != ST_COLD) |-> ($past(state) == ST_RUN));
endmodule

// File: rtl/lpw_link_power.sv
module lpw_link_power
    import lpw_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int PD_ADDR     = 'h26,
    parameter int RST_ADDR    = 'h00,
    parameter int HALT_BIT    = 12,
    parameter int WARM_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sync_in,
    input  logic              bit_clk_src,
    input  logic              sdata_src,
    output logic              bit_clk_out,
    output logic              sdata_in_out,
    output logic              link_halted,
    output logic              halt_bit_clr,
    output logic              reg_defaults
);
    lpw_state_t state;
    logic       halt_hit;
    logic       rstreg_hit;
    logic       timer_en;
    logic       timer_done;
    logic       running;

    lpw_wr_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PD_ADDR (PD_ADDR),
        .RST_ADDR(RST_ADDR),
        .HALT_BIT(HALT_BIT)
    ) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .halt_hit  (halt_hit),
        .rstreg_hit(rstreg_hit)
    );

    lpw_wake_timer #(
        .WARM_CYCLES(WARM_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (timer_en),
        .reached(timer_done)
    );

    lpw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_hit    (halt_hit),
        .rstreg_hit  (rstreg_hit),
        .sync_in     (sync_in),
        .timer_done  (timer_done),
        .state       (state),
        .timer_en    (timer_en),
        .halt_bit_clr(halt_bit_clr),
        .reg_defaults(reg_defaults)
    );

    always_comb begin
        running      = (state == ST_RUN);
        link_halted  = !running;
        bit_clk_out  = running && bit_clk_src;
        sdata_in_out = running && sdata_src;
    end

    // R6: leaving the halt always passes through the halt-bit clear strobe or a cold reset
    p_wake_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_halted) |-> ($past(halt_bit_clr) || $past(reg_defaults)));
endmodule

// File: tb/lpw_link_power_test.sv
module lpw_link_power_test;
    localparam int W = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sync_in = 1'b0;
    logic        bit_clk_src = 1'b1;
    logic        sdata_src = 1'b1;
    logic        bit_clk_out, sdata_in_out, link_halted, halt_bit_clr, reg_defaults;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpw_link_power #(.WARM_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .bit_clk_src(bit_clk_src),
        .sdata_src(sdata_src), .bit_clk_out(bit_clk_out),
        .sdata_in_out(sdata_in_out), .link_halted(link_halted),
        .halt_bit_clr(halt_bit_clr), .reg_defaults(reg_defaults)
    );

    function automatic bit exp_halt(input logic [6:0] a, input logic [15:0] d);
        return (a == 7'h26) && d[12];
    endfunction

    function automatic bit exp_rstreg(input logic [6:0] a);
        return a == 7'h00;
    endfunction

    function automatic bit exp_wake(input int len);
        return len >= W;
    endfunction

    function automatic logic [4:0] running_vec();
        return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {bit_clk_out, sdata_in_out, link_halted, halt_bit_clr, reg_defaults};
    endfunction

    task automatic write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // Drives sync high for len sampling edges, then checks the outcome.
    task automatic pulse_and_judge(input int len, input string req);
        @(negedge clk);
        sync_in = 1'b1;
        repeat (len) @(negedge clk);
        chk(req, {31'd0, link_halted}, 32'd1);
        sync_in = 1'b0;
        @(negedge clk);
        if (exp_wake(len)) begin
            chk(req, {27'd0, outs()}, {27'd0, 5'b00110});
            @(negedge clk);
            chk(req, {27'd0, outs()}, {27'd0, running_vec()});
        end else begin
            chk(req, {27'd0, outs()}, {27'd0, 5'b00100});
            @(negedge clk);
            chk(req, {27'd0, outs()}, {27'd0, 5'b00100});
        end
    endtask

    task automatic cold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #3;
        chk("R1 reset", {27'd0, outs()}, {27'd0, 5'b00101});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 release", {27'd0, outs()}, {27'd0, running_vec()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        #5;
        chk("R1 in reset", {27'd0, outs()}, {27'd0, 5'b00101});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {27'd0, outs()}, {27'd0, running_vec()});
        sdata_src = 1'b0;
        #1;
        chk("R1 data follows", {31'd0, sdata_in_out}, 32'd0);
        sdata_src = 1'b1;

        // R3 directed: halt address with bit 12 clear, other address with bit 12 set
        write(7'h26, 16'hEFFF);
        chk("R3 bit clear", {27'd0, outs()}, {27'd0, running_vec()});
        write(7'h24, 16'h1000);
        chk("R3 other addr", {27'd0, outs()}, {27'd0, running_vec()});

        // R7 directed: reset-register write pulses for one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h00; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 pulse", {27'd0, outs()}, {27'd0, 5'b11001});
        @(negedge clk);
        chk("R7 pulse ends", {27'd0, outs()}, {27'd0, running_vec()});

        // R2 directed halt
        write(7'h26, 16'h1000);
        chk("R2 halt", {27'd0, outs()}, {27'd0, 5'b00100});
        // R4: writes while halted ignored, sync low holds
        write(7'h00, 16'h0000);
        @(negedge clk);
        chk("R4 rstreg ignored", {27'd0, outs()}, {27'd0, 5'b00100});
        write(7'h26, 16'hFFFF);
        repeat (3 * W) @(negedge clk);
        chk("R4 sync low holds", {27'd0, outs()}, {27'd0, 5'b00100});

        // R5 / R6 boundaries
        pulse_and_judge(1, "R5 len 1");
        pulse_and_judge(W - 1, "R5 len W-1");
        pulse_and_judge(W, "R6 len W");
        chk("R7 no defaults on warm wake", {31'd0, reg_defaults}, 32'd0);

        // R8: cold reset during halt, right after a short sync pulse
        write(7'h26, 16'h1000);
        pulse_and_judge(W / 2, "R5 mid");
        cold_reset();
        chk("R8 no clr strobe", {31'd0, halt_bit_clr}, 32'd0);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [6:0]  a;
            logic [15:0] d;
            int          sel;
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? 7'h26 : (sel == 1) ? 7'h00 : 7'($urandom_range(1, 127));
            d = 16'($urandom);
            @(negedge clk);
            wr_en = 1'b1; wr_addr = a; wr_data = d;
            @(negedge clk);
            wr_en = 1'b0;
            if (exp_halt(a, d)) begin
                chk("R2 random halt", {27'd0, outs()}, {27'd0, 5'b00100});
                begin
                    int len;
                    len = $urandom_range(1, 2 * W);
                    pulse_and_judge(len, "R6 random pulse");
                    if (!exp_wake(len)) pulse_and_judge(W + 3, "R6 random retry");
                end
            end else if (exp_rstreg(a)) begin
                chk("R7 random pulse", {27'd0, outs()}, {27'd0, 5'b11001});
                @(negedge clk);
            end else begin
                chk("R3 random no effect", {27'd0, outs()}, {27'd0, running_vec()});
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule